// File: doc/BRIEF.md
# Bit-Column-Serial Dot-Product Engine

This engine forms the dot product of a group of signed 8-bit activations with a group of 8-bit weights held as a sign bit plus a 7-bit magnitude. The activations and weight signs are captured once when a group starts. After that the engine takes one weight bit-column per cycle. A bit-column holds the magnitude bit of one significance from every lane, and it arrives with that significance as a shift amount. Columns whose bits are all zero never need to be presented, so a group costs one cycle per column that carries information.

Each lane multiplies its activation by a single weight bit and applies its sign. All lane products of the column are summed first, and the column sum is then shifted once by its significance and added into an accumulator that stays inside the engine. A marker on the final column releases the accumulated value as a one-cycle valid pulse. A group with no non-zero columns at all is started with an empty flag and yields zero without any column cycles.

Top module: `bcol_mac_engine`

## Requirements
- R1: Out of reset, `resValid` is low and `resData` is zero.
- R2: A lane whose column bit is 1 contributes its activation, negated when its sign bit is 1; a lane whose column bit is 0 contributes nothing.
- R3: Each accepted column adds (sum of its lane contributions) multiplied by 2 to the power `colShift` (0 to 6) to the accumulator, so the result equals the sum over lanes of activation times signed magnitude.
- R4: Activations and sign bits are taken only in a `grpLoad` cycle; changes on `actIn` and `signIn` during the columns of a group have no effect on its result.
- R5: `colBits`, `colShift` and `colLast` are ignored in cycles where `colValid` is low.
- R6: `resValid` pulses high for one cycle exactly two cycles after the cycle in which the column with `colLast` high is accepted, and `resData` then holds that value until the next result.
- R7: A `grpLoad` with `grpEmpty` high produces `resValid` with `resData` equal to 0 two cycles later, with no columns presented.
- R8: `grpLoad` clears the accumulator, so no value carries from one group into the next.
- R9: The accumulator is wide enough (activation width + magnitude width + log2 of the lane count + 1) that no group can overflow it, including every lane at activation -128 with magnitude 127.
- R10: The result does not depend on the order in which the columns of a group are presented, and presenting an all-zero column leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| grpLoad | input | 1 | Start a group: capture activations and signs, clear accumulator |
| grpEmpty | input | 1 | With `grpLoad`: the group has no non-zero columns |
| actIn | input | LANES*8 | Two's complement activations, lane n in bits [8n+7:8n] |
| signIn | input | LANES | Weight sign per lane, 1 = negative |
| colValid | input | 1 | A bit-column is presented this cycle |
| colBits | input | LANES | Magnitude bit of each lane for this column |
| colShift | input | 3 | Significance of the column, 0 to 6 |
| colLast | input | 1 | This column is the last of the group |
| resValid | output | 1 | One-cycle pulse: `resData` holds a new group result |
| resData | output | ACC_W | Signed group result |

## Verification
The bench builds the engine with 16 lanes, the middle of the supported 8, 16 and 32, which gives a 20-bit accumulator and lets an all-extreme group reach -260096 and +260096 without wrapping. Groups are run with columns in both significance orders, with idle cycles carrying junk column data and changed activations between columns, with explicit all-zero columns, and as empty groups, while a scoreboard compares each result and its arrival cycle.

// File: rtl/bcol_pkg.sv
package bcol_pkg;

  // Strobes from the control pipeline to the datapath
  typedef struct packed {
    logic loadGrp;     // capture operands, clear accumulator
    logic colCapture;  // register lane sum and shift of the column
    logic accEn;       // add shifted column sum into accumulator
    logic accFinish;   // copy accumulator sum to the result register
    logic zeroFinish;  // empty group: result register to zero
  } bcolStrobe_t;

endpackage

// File: rtl/bcol_ctrl.sv
module bcol_ctrl
  import bcol_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        grpLoad,
  input  logic        grpEmpty,
  input  logic        colValid,
  input  logic        colLast,
  output bcolStrobe_t strb,
  output logic        resValid
);

  logic colV1;
  logic last1;
  logic empty1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colV1    <= 1'b0;
      last1    <= 1'b0;
      empty1   <= 1'b0;
      resValid <= 1'b0;
    end else begin
      colV1    <= colValid;
      last1    <= colValid & colLast;
      empty1   <= grpLoad & grpEmpty;
      resValid <= (colV1 & last1) | empty1;
    end
  end

  always_comb begin
    strb.loadGrp    = grpLoad;
    strb.colCapture = colValid;
    strb.accEn      = colV1;
    strb.accFinish  = colV1 & last1;
    strb.zeroFinish = empty1;
  end

  AST_LAST_TO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && colLast) |-> ##2 resValid); // R6

  AST_EMPTY_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (grpLoad && grpEmpty) |-> ##2 resValid); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    (!colValid && !(grpLoad && grpEmpty)) |-> ##2 !resValid); // R5

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    grpLoad |-> !colV1 && !colValid); // R8

endmodule

// File: rtl/bcol_datapath.sv
module bcol_datapath
  import bcol_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ACT_W = 8,
  parameter int MAG_W = 7,
  localparam int LANE_LOG = $clog2(LANES),
  localparam int SHIFT_W  = $clog2(MAG_W),
  localparam int SUM_W    = ACT_W + 1 + LANE_LOG,
  localparam int ACC_W    = ACT_W + MAG_W + LANE_LOG + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  bcolStrobe_t             strb,
  input  logic [LANES*ACT_W-1:0]  actIn,
  input  logic [LANES-1:0]        signIn,
  input  logic [LANES-1:0]        colBits,
  input  logic [SHIFT_W-1:0]      colShift,
  output logic signed [ACC_W-1:0] resData
);

  logic signed [ACT_W-1:0] actReg [LANES];
  logic [LANES-1:0]        signReg;
  logic signed [ACT_W:0]   prod [LANES];
  logic signed [SUM_W-1:0] laneSum;
  logic signed [SUM_W-1:0] sumReg;
  logic [SHIFT_W-1:0]      shiftReg;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] shifted;
  logic signed [ACC_W:0]   wideSum;
  logic signed [ACC_W-1:0] accNext;

  // Operand registers, loaded once per group
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < LANES; l++) actReg[l] <= '0;
      signReg <= '0;
    end else if (strb.loadGrp) begin
      for (int l = 0; l < LANES; l++) actReg[l] <= actIn[l*ACT_W +: ACT_W];
      signReg <= signIn;
    end
  end

  // 1-bit by ACT_W-bit sign-magnitude multipliers
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [ACT_W:0] actExt;
    assign actExt = {actReg[l][ACT_W-1], actReg[l]};
    always_comb begin
      if (!colBits[l])      prod[l] = '0;
      else if (signReg[l])  prod[l] = -actExt;
      else                  prod[l] = actExt;
    end
  end

  // Cross-lane sum of the column
  always_comb begin
    laneSum = '0;
    for (int l = 0; l < LANES; l++)
      laneSum = laneSum + {{(SUM_W-ACT_W-1){prod[l][ACT_W]}}, prod[l]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg   <= '0;
      shiftReg <= '0;
    end else if (strb.colCapture) begin
      sumReg   <= laneSum;
      shiftReg <= colShift;
    end
  end

  // Single shift per column, then accumulate
  assign shifted = {{(ACC_W-SUM_W){sumReg[SUM_W-1]}}, sumReg} <<< shiftReg;
  assign wideSum = {acc[ACC_W-1], acc} + {shifted[ACC_W-1], shifted};
  assign accNext = wideSum[ACC_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      resData <= '0;
    end else begin
      if (strb.loadGrp)     acc <= '0;
      else if (strb.accEn)  acc <= accNext;
      if (strb.accFinish)       resData <= accNext;
      else if (strb.zeroFinish) resData <= '0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.accEn |-> wideSum[ACC_W] == wideSum[ACC_W-1]); // R9

  AST_ZERO_COLUMN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.colCapture && colBits == '0) |=> sumReg == '0); // R2

  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadGrp |=> $stable(signReg) && $stable(actReg[0])); // R4

  AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadGrp |=> acc == '0); // R8

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroFinish |=> resData == '0); // R7

endmodule

// File: rtl/bcol_mac_engine.sv
module bcol_mac_engine
  import bcol_pkg::*;
#(
  parameter int LANES = 8,
  parameter int ACT_W = 8,
  parameter int MAG_W = 7,
  localparam int LANE_LOG = $clog2(LANES),
  localparam int SHIFT_W  = $clog2(MAG_W),
  localparam int ACC_W    = ACT_W + MAG_W + LANE_LOG + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    grpLoad,
  input  logic                    grpEmpty,
  input  logic [LANES*ACT_W-1:0]  actIn,
  input  logic [LANES-1:0]        signIn,
  input  logic                    colValid,
  input  logic [LANES-1:0]        colBits,
  input  logic [SHIFT_W-1:0]      colShift,
  input  logic                    colLast,
  output logic                    resValid,
  output logic signed [ACC_W-1:0] resData
);

  bcolStrobe_t strb;

  bcol_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .grpLoad  (grpLoad),
    .grpEmpty (grpEmpty),
    .colValid (colValid),
    .colLast  (colLast),
    .strb     (strb),
    .resValid (resValid)
  );

  bcol_datapath #(
    .LANES (LANES),
    .ACT_W (ACT_W),
    .MAG_W (MAG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .actIn    (actIn),
    .signIn   (signIn),
    .colBits  (colBits),
    .colShift (colShift),
    .resData  (resData)
  );

endmodule

// File: tb/bcol_mac_engine_tb.sv
module bcol_mac_engine_tb;

  localparam int LANES = 16;
  localparam int ACT_W = 8;
  localparam int MAG_W = 7;
  localparam int ACC_W = ACT_W + MAG_W + $clog2(LANES) + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grpLoad = 1'b0;
  logic grpEmpty = 1'b0;
  logic [LANES*ACT_W-1:0] actIn = '0;
  logic [LANES-1:0] signIn = '0;
  logic colValid = 1'b0;
  logic [LANES-1:0] colBits = '0;
  logic [2:0] colShift = '0;
  logic colLast = 1'b0;
  logic resValid;
  logic signed [ACC_W-1:0] resData;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  int    expVal[$];
  int    expDue[$];
  string expTag[$];

  logic signed [7:0] acts  [LANES];
  logic [6:0]        mags  [LANES];
  logic              signs [LANES];

  always #4 clk = ~clk; // 125 MHz

  bcol_mac_engine #(.LANES(LANES), .ACT_W(ACT_W), .MAG_W(MAG_W)) u_dut (
    .clk(clk), .rstN(rstN), .grpLoad(grpLoad), .grpEmpty(grpEmpty),
    .actIn(actIn), .signIn(signIn), .colValid(colValid), .colBits(colBits),
    .colShift(colShift), .colLast(colLast), .resValid(resValid), .resData(resData)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every result pulse
  always @(negedge clk) begin
    if (rstN && resValid) begin
      if (expVal.size() == 0) begin
        check("R5 unexpected result pulse", 1, 0);
      end else begin
        int v; int d; string t;
        v = expVal.pop_front(); d = expDue.pop_front(); t = expTag.pop_front();
        check({t, " value"}, int'(resData), v);
        check("R6 result cycle", cyc, d);
      end
    end
  end

  function automatic int expected();
    int s = 0;
    for (int l = 0; l < LANES; l++)
      s += (signs[l] ? -1 : 1) * int'(acts[l]) * int'(mags[l]);
    return s;
  endfunction

  // Driver: runs one group and queues its expected result
  task automatic runGroup(input string tag, input bit msbFirst,
                          input bit keepZero, input bit jitter);
    int expv;
    int nz;
    int total;
    int sent;
    logic [LANES-1:0] col;
    expv = expected();
    nz = 0;
    for (int b = 0; b < MAG_W; b++) begin
      for (int l = 0; l < LANES; l++) col[l] = mags[l][b];
      if (col != '0) nz++;
    end
    total = keepZero ? MAG_W : nz;
    @(negedge clk);
    grpLoad = 1'b1;
    for (int l = 0; l < LANES; l++) begin
      actIn[l*ACT_W +: ACT_W] = acts[l];
      signIn[l] = signs[l];
    end
    grpEmpty = (total == 0);
    if (total == 0) begin
      expVal.push_back(expv); expDue.push_back(cyc + 2); expTag.push_back(tag);
    end
    @(negedge clk);
    grpLoad = 1'b0;
    grpEmpty = 1'b0;
    actIn = ~actIn;   // R4: operands change after load
    signIn = ~signIn;
    sent = 0;
    for (int k = 0; k < MAG_W; k++) begin
      int b;
      b = msbFirst ? (MAG_W - 1 - k) : k;
      for (int l = 0; l < LANES; l++) col[l] = mags[l][b];
      if (!keepZero && col == '0) continue;
      sent++;
      if (jitter) begin // R5: junk with colValid low
        colValid = 1'b0; colBits = '1; colShift = 3'd5; colLast = 1'b1;
        @(negedge clk);
      end
      colValid = 1'b1;
      colBits = col;
      colShift = 3'(b);
      colLast = (sent == total);
      if (colLast) begin
        expVal.push_back(expv); expDue.push_back(cyc + 2); expTag.push_back(tag);
      end
      @(negedge clk);
    end
    colValid = 1'b0; colLast = 1'b0; colBits = '0; colShift = '0;
    repeat (4) @(negedge clk);
    check("R6 result held", int'(resData), expv);
    check("R6 single pulse", int'(resValid), 0);
  endtask

  task automatic clearOps();
    for (int l = 0; l < LANES; l++) begin
      acts[l] = '0; mags[l] = '0; signs[l] = 1'b0;
    end
  endtask

  task automatic randOps();
    for (int l = 0; l < LANES; l++) begin
      acts[l] = 8'($urandom);
      mags[l] = 7'($urandom);
      signs[l] = 1'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(resValid), 0);
    check("R1 reset data", int'(resData), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: one lane, positive then negative weight
    clearOps(); acts[3] = 8'sd5; mags[3] = 7'd1;
    runGroup("R2 single lane positive", 1'b0, 1'b0, 1'b0);
    signs[3] = 1'b1;
    runGroup("R2 single lane negated", 1'b0, 1'b0, 1'b0);
    acts[9] = -8'sd7; mags[9] = 7'd4; signs[9] = 1'b1;
    runGroup("R2 two lanes mixed sign", 1'b0, 1'b0, 1'b0);

    // R3: random groups
    for (int n = 0; n < 6; n++) begin
      randOps();
      runGroup("R3 random group", n[0], 1'b0, 1'b0);
    end

    // R10: same operands, both orders and with zero columns sent
    randOps();
    for (int l = 0; l < LANES; l++) mags[l][2] = 1'b0;
    runGroup("R10 lsb first", 1'b0, 1'b0, 1'b0);
    runGroup("R10 msb first", 1'b1, 1'b0, 1'b0);
    runGroup("R10 zero columns sent", 1'b1, 1'b1, 1'b0);

    // R9: extremes
    for (int l = 0; l < LANES; l++) begin
      acts[l] = -8'sd128; mags[l] = 7'd127; signs[l] = 1'b0;
    end
    runGroup("R9 most negative", 1'b0, 1'b0, 1'b0);
    for (int l = 0; l < LANES; l++) signs[l] = 1'b1;
    runGroup("R9 most positive", 1'b1, 1'b0, 1'b0);

    // R8: small group right after the extreme one
    clearOps(); acts[0] = 8'sd1; mags[0] = 7'd64;
    runGroup("R8 no carry over", 1'b0, 1'b0, 1'b0);

    // R7: empty group, then after a non-zero result
    clearOps(); acts[5] = 8'sd99;
    runGroup("R7 empty group", 1'b0, 1'b0, 1'b0);

    // R4 and R5: idle junk cycles between columns
    for (int n = 0; n < 3; n++) begin
      randOps();
      runGroup("R5 idle junk between columns", n[0], 1'b0, 1'b1);
    end

    repeat (4) @(negedge clk);
    check("R6 scoreboard drained", expVal.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule